// File: doc/BRIEF.md
# Handshaked quadratic sequence generator

The block produces the values x(x+1) for x = 0, 1, 2, ... in order and hands each one to a consumer over a four-phase return-to-zero req/ack handshake. An internal 26-bit counter holds the next x. Each product is formed by an iterative shift-and-add squarer that starts from a = b = c = x, handles two multiplier bits per clock, and stops as soon as the remaining multiplier bits are all zero. The 26-bit result r is reduced to a 15-bit output word, the low 15 bits of r XOR (r >> 15).

A consumer that wants a free-running stream ties ack to req. While a word is being handed over, the next value is already being computed. Before the controller uses ack, the input passes through a synchroniser. Reset is synchronous and active high.

Top module: `qsg_top`

## Requirements
- R1: While reset is high and in the first cycle after it, req is low and the word is 0. After any reset the first word offered corresponds to x = 0, and req rises one clock after reset falls.
- R2: The k-th word offered after reset (k = 0, 1, 2, ...) is derived from r = (k*k + k) mod 2^26, which gives 0, 2, 6, 12, ... before folding.
- R3: The word equals bits [14:0] of r XOR (r >> 15). For r < 2^15 it is r itself.
- R4: req rises only after the synchronised ack has been low and the next result is complete. Once the result is ready, req rises exactly 4 clocks after ack falls, and req stays low for as long as ack stays high.
- R5: req stays high for as long as ack stays low. req falls exactly 3 clocks after ack rises.
- R6: The word does not change while req is high.
- R7: With ack tied to req, the block produces every value in sequence without stalling the handshake or skipping a value.
- R8: With ack tied to req, the interval from the req rise that presents x - 1 to the req rise that presents x (x >= 1) is max(7, ceil(n/2) + 1) clocks, where n is the bit length of x. The 7-clock floor is the handshake round trip. The other term is the early-exit squarer time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_i | input | 1 | Consumer acknowledge, may be asynchronous |
| req_o | output | 1 | Word valid request |
| word_o | output | 15 | Folded result word |

## Verification
The assertions assume that ack follows the four-phase order: it rises only while req is high and falls only after req has dropped. They also assume that ack changes are held long enough for the two-stage synchroniser to see them.

The bench drives ack from tasks at the falling clock edge and never toggles it out of protocol order. It uses random dwell times before each ack edge, and it sometimes holds ack high for many cycles after req has fallen. In free-running mode ack is req itself, so the protocol order holds by construction.

// File: rtl/qsg_pkg.sv
package qsg_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_HOLD    = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_t;
endpackage

// File: rtl/qsg_sync.sv
module qsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qsg_squarer.sv
// Early-exit shift-and-add squarer: the result is x + x*x, with UNROLL multiplier bits per clock.
module qsg_squarer #(
  parameter int W      = 26,
  parameter int UNROLL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] x_i,
  output logic         busy_o,
  output logic [W-1:0] prod_o
);
  logic [W-1:0] a_q, b_q, c_q;
  logic         busy_q;

  // Unrolled halves: each tests one bit, adds, doubles and halves.
  logic [W-1:0] a_s [UNROLL+1];
  logic [W-1:0] b_s [UNROLL+1];
  logic [W-1:0] c_s [UNROLL+1];

  assign a_s[0] = a_q;
  assign b_s[0] = b_q;
  assign c_s[0] = c_q;

  for (genvar i = 0; i < UNROLL; i++) begin : g_half
    assign c_s[i+1] = c_s[i] + (b_s[i][0] ? a_s[i] : '0);
    assign a_s[i+1] = a_s[i] << 1;
    assign b_s[i+1] = b_s[i] >> 1;
  end

  // Named internal events for the checks.
  logic step_en;
  logic last_step;
  assign step_en   = busy_q && !start_i;
  assign last_step = step_en && (b_s[UNROLL] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      a_q    <= x_i;
      b_q    <= x_i;
      c_q    <= x_i;
      busy_q <= (x_i != '0);
    end else if (step_en) begin
      a_q    <= a_s[UNROLL];
      b_q    <= b_s[UNROLL];
      c_q    <= c_s[UNROLL];
      busy_q <= !last_step;
    end
  end

  assign busy_o = busy_q;
  assign prod_o = c_q;

  // R4
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i) |=> $stable(c_q));

  // R8
  exit_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !start_i && b_s[UNROLL] == '0) |=> !busy_q);
endmodule

// File: rtl/qsg_hs.sv
module qsg_hs
  import qsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_s_i,
  input  logic ready_i,
  output logic req_o,
  output logic load_o
);
  hs_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (ready_i && !ack_s_i) begin
          state_d = HS_HOLD;
          load_o  = 1'b1;
        end
      end
      HS_HOLD:    if (ack_s_i)  state_d = HS_RELEASE;
      HS_RELEASE: if (!ack_s_i) state_d = HS_IDLE;
      default:    state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_IDLE;
    else     state_q <= state_d;
  end

  assign req_o = (state_q == HS_HOLD);

  // R4
  req_rise_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> ($past(ready_i) && !$past(ack_s_i)));

  // R5
  req_fall_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> $past(ack_s_i));
endmodule

// File: rtl/qsg_top.sv
module qsg_top #(
  parameter int VAL_W       = 26,
  parameter int OUT_W       = 15,
  parameter int UNROLL      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_i,
  output logic             req_o,
  output logic [OUT_W-1:0] word_o
);
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  function automatic logic [OUT_W-1:0] fold_word(input logic [VAL_W-1:0] r);
    logic [VAL_W-1:0] t;
    t = r ^ (r >> OUT_W);
    return t[OUT_W-1:0];
  endfunction

  logic             ack_s;
  logic             sq_busy;
  logic [VAL_W-1:0] sq_prod;
  logic             load;
  logic [VAL_W-1:0] x_q;
  logic [VAL_W-1:0] x_next;
  logic [OUT_W-1:0] word_q;

  assign x_next = x_q + ONE;

  qsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ack_i),
    .q_o (ack_s)
  );

  qsg_squarer #(.W(VAL_W), .UNROLL(UNROLL)) u_sq (
    .clk     (clk),
    .rst     (rst),
    .start_i (load),
    .x_i     (x_next),
    .busy_o  (sq_busy),
    .prod_o  (sq_prod)
  );

  qsg_hs u_hs (
    .clk     (clk),
    .rst     (rst),
    .ack_s_i (ack_s),
    .ready_i (!sq_busy),
    .req_o   (req_o),
    .load_o  (load)
  );

  // The squarer's reset state (a = b = c = 0) is already the result for x = 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      word_q <= '0;
    end else if (load) begin
      x_q    <= x_next;
      word_q <= fold_word(sq_prod);
    end
  end

  assign word_o = word_q;

  // R6
  word_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && $past(req_o)) |-> $stable(word_o));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> (x_q == $past(x_q) + ONE));
endmodule

// File: tb/tb_qsg_top.sv
module tb_qsg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ack_drv = 1'b0;
  logic        tie = 1'b0;
  logic        req;
  logic [14:0] word;
  logic        ack;

  assign ack = tie ? req : ack_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  qsg_top dut (
    .clk    (clk),
    .rst    (rst),
    .ack_i  (ack),
    .req_o  (req),
    .word_o (word)
  );

  function automatic longint exp_word(longint x);
    longint r;
    r = (x * x + x) & 64'h3FFFFFF;
    return (r ^ (r >> 15)) & 64'h7FFF;
  endfunction

  function automatic longint exp_gap(longint x);
    int n = 0;
    int s;
    while ((x >> n) != 0) n++;
    s = (n + 1) / 2;
    return (s + 1 > 7) ? s + 1 : 7;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl, output int waited);
    waited = 0;
    while (req !== lvl && waited < 300) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic do_reset();
    tie = 1'b0;
    ack_drv = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(req === 1'b0, "R1 req in reset", req, 0);
    check(word === 15'd0, "R1 word in reset", word, 0);
    rst = 1'b0;
    @(negedge clk);
    check(req === 1'b1, "R1 req one clock after reset", req, 1);
  endtask

  task automatic slow_handshake(int count);
    for (int k = 0; k < count; k++) begin
      int w;
      int d;
      logic [14:0] held;
      wait_req(1'b1, w);
      check(req === 1'b1, "R4 req offered", req, 1);
      check(word == exp_word(k), "R2 R3 word value", word, exp_word(k));
      held = word;
      d = $urandom_range(0, 6);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        check(req === 1'b1, "R5 req held while ack low", req, 1);
        check(word === held, "R6 word stable", word, held);
      end
      ack_drv = 1'b1;
      w = 0;
      while (req === 1'b1 && w < 20) begin
        @(negedge clk);
        w++;
        if (req === 1'b1)
          check(word === held, "R6 word stable before release", word, held);
      end
      check(w == 3, "R5 req falls 3 clocks after ack", w, 3);
      d = (k % 3 == 2) ? 20 : $urandom_range(0, 8);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        check(req === 1'b0, "R4 req low while ack high", req, 0);
      end
      ack_drv = 1'b0;
      w = 0;
      while (req !== 1'b1 && w < 20) begin
        @(negedge clk);
        w++;
      end
      check(w == 4, "R4 req rises 4 clocks after ack falls", w, 4);
    end
  endtask

  task automatic free_run(int count);
    longint prev = 0;
    tie = 1'b1;
    for (int k = 0; k < count; k++) begin
      int w;
      longint t;
      wait_req(1'b1, w);
      t = cyc;
      if (req !== 1'b1) begin
        check(1'b0, "R7 stream stalled", k, k);
        break;
      end
      check(word == exp_word(k), "R7 R2 streamed word", word, exp_word(k));
      if (k > 0)
        check((t - prev) == exp_gap(k), "R8 interval", t - prev, exp_gap(k));
      prev = t;
      wait_req(1'b0, w);
    end
    tie = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    slow_handshake(14);
    do_reset();
    slow_handshake(3);
    do_reset();
    free_run(9000);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule